// File: doc/BRIEF.md
# Direct-Mapped Page Translation Cache

This block keeps a small direct-mapped table of recent virtual-page to host-page translations and sits in front of a slower translation path. Each request carries a virtual address, a write flag and a translate-only flag. The block looks the request up in one cycle, using the virtual address bits just above the page offset as the index. On a hit it answers in the following cycle. On a miss it hands the request to the slow path through a req/ack handshake. It holds the request and lowers its ready output until the acknowledge arrives. It then refills the entry and answers from the returned data.

A normal memory entry answers with a host address, which is the stored host page base joined with the request's page offset. A device entry answers with a device id and a device offset. Both are cut from the stored host page number. A translate-only request answers with the stored physical page number. A write to an entry marked copy-on-write always takes the slow path. In 32-bit mode only the low 32 bits of the virtual address take part in the tag compare. A flush input clears every entry in one cycle, and it must be pulsed whenever the address mode changes.

Top module: `xlat_cache`

## Requirements
- R1: After reset, req_ready_o is 1, resp_valid_o and slow_req_o are 0, and every entry is invalid, so the first request to any page misses.
- R2: A request hits only when its entry is valid and its virtual page number equals the stored tag. A hit raises resp_valid_o in the next cycle and raises no slow request.
- R3: A hit to a memory entry answers with resp_kind_o = 0 and resp_data_o = {stored host page number, request page offset}.
- R4: On a miss, slow_req_o rises in the next cycle, carrying the request's address on slow_va_o and its write flag on slow_write_o. slow_req_o, slow_va_o and a low req_ready_o are all held until slow_ack_i.
- R5: An acknowledge without error writes the entry from the slow response. In the next cycle the block answers from that data. Later requests to the same page then hit.
- R6: A write that matches an entry whose copy-on-write flag is set is handled as a miss. A read to that entry still hits.
- R7: A device entry answers with resp_kind_o = 1. resp_devid_o is the top DEVID_W bits of the host page number. resp_data_o is the remaining host page bits joined with the page offset. resp_devid_o is 0 for every other kind.
- R8: A translate-only request answers with resp_kind_o = 2 and resp_data_o = the stored physical page number, zero-extended.
- R9: An acknowledge with slow_err_i set answers with resp_kind_o = 3 and resp_data_o = 0, and it leaves the entry unchanged.
- R10: With mode64_i = 0, only virtual address bits 31 and below take part in the tag compare. With mode64_i = 1, all bits do.
- R11: A flush_i pulse invalidates all entries in one cycle.
- R12: Two pages with the same index bits (the address bits directly above the page offset) share one entry, and each evicts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| mode64_i | input | 1 | 1: compare the full address, 0: compare the low 32 bits only |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_va_i | input | VA_W | Virtual address |
| req_write_i | input | 1 | Request is a write |
| req_xlate_i | input | 1 | Translate-only request |
| resp_valid_o | output | 1 | Response present for one cycle |
| resp_kind_o | output | 2 | 0 memory, 1 device, 2 page number, 3 fault |
| resp_data_o | output | HA_W | Host address, device offset or page number |
| resp_devid_o | output | DEVID_W | Device id for kind 1, else 0 |
| slow_req_o | output | 1 | Slow lookup request |
| slow_va_o | output | VA_W | Address sent to the slow path |
| slow_write_o | output | 1 | Write flag sent to the slow path |
| slow_ack_i | input | 1 | Slow lookup done |
| slow_err_i | input | 1 | Slow lookup failed |
| slow_ppn_i | input | PPN_W | Returned physical page number |
| slow_hpn_i | input | HA_W-PAGE_SHIFT | Returned host page number |
| slow_dev_i | input | 1 | Returned entry is a device region |
| slow_cow_i | input | 1 | Returned entry is copy-on-write |

## Verification
The assertions assume that slow_ack_i comes only while slow_req_o is high. They also assume that flush_i and mode changes happen only while the block is idle, with no lookup in flight. The stimulus raises the acknowledge only after it has seen slow_req_o high, and it waits a few cycles with the acknowledge low so that the hold is exercised. It drives flush and mode changes only between requests, and it flushes on every mode change.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    RK_MEM   = 2'd0,
    RK_DEV   = 2'd1,
    RK_PAGE  = 2'd2,
    RK_FAULT = 2'd3
  } resp_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/xlat_tag_store.sv
module xlat_tag_store #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 52,
  parameter int PPN_W   = 28,
  parameter int HPN_W   = 36,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [VPN_W-1:0] rd_vpn_o,
  output logic [PPN_W-1:0] rd_ppn_o,
  output logic [HPN_W-1:0] rd_hpn_o,
  output logic             rd_dev_o,
  output logic             rd_cow_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [HPN_W-1:0] wr_hpn_i,
  input  logic             wr_dev_i,
  input  logic             wr_cow_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [HPN_W-1:0]   hpn_q [ENTRIES];
  logic [ENTRIES-1:0] dev_q;
  logic [ENTRIES-1:0] cow_q;

  // flush wins over a refill in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk_i) begin
        if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
          vpn_q[g] <= wr_vpn_i;
          ppn_q[g] <= wr_ppn_i;
          hpn_q[g] <= wr_hpn_i;
          dev_q[g] <= wr_dev_i;
          cow_q[g] <= wr_cow_i;
        end
      end
    end
  endgenerate

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_vpn_o   = vpn_q[rd_idx_i];
  assign rd_ppn_o   = ppn_q[rd_idx_i];
  assign rd_hpn_o   = hpn_q[rd_idx_i];
  assign rd_dev_o   = dev_q[rd_idx_i];
  assign rd_cow_o   = cow_q[rd_idx_i];

  // R11: one flush cycle leaves nothing valid
  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int VPN_W      = 52,
  parameter int PAGE_SHIFT = 12,
  localparam int VPN32_W   = 32 - PAGE_SHIFT
) (
  input  logic             mode64_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             write_i,
  input  logic             ent_valid_i,
  input  logic [VPN_W-1:0] ent_vpn_i,
  input  logic             ent_cow_i,
  output logic             hit_o
);
  logic tag_eq;

  always_comb begin
    if (mode64_i) tag_eq = (req_vpn_i == ent_vpn_i);
    else          tag_eq = (req_vpn_i[VPN32_W-1:0] == ent_vpn_i[VPN32_W-1:0]);
  end

  // a write to a copy-on-write page must go to the slow path
  assign hit_o = ent_valid_i && tag_eq && !(write_i && ent_cow_i);
endmodule

// File: rtl/xlat_resp_form.sv
module xlat_resp_form
  import xlat_pkg::*;
#(
  parameter int HA_W       = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_W      = 28,
  parameter int DEVID_W    = 8,
  localparam int HPN_W     = HA_W - PAGE_SHIFT
) (
  input  logic [HPN_W-1:0]      hpn_i,
  input  logic [PPN_W-1:0]      ppn_i,
  input  logic                  dev_i,
  input  logic                  xlate_i,
  input  logic [PAGE_SHIFT-1:0] off_i,
  output resp_kind_e            kind_o,
  output logic [HA_W-1:0]       data_o,
  output logic [DEVID_W-1:0]    devid_o
);
  always_comb begin
    kind_o  = RK_MEM;
    data_o  = {hpn_i, off_i};
    devid_o = '0;
    if (xlate_i) begin
      kind_o = RK_PAGE;
      data_o = {{(HA_W-PPN_W){1'b0}}, ppn_i};
    end else if (dev_i) begin
      kind_o  = RK_DEV;
      devid_o = hpn_i[HPN_W-1 -: DEVID_W];
      data_o  = {{DEVID_W{1'b0}}, hpn_i[HPN_W-DEVID_W-1:0], off_i};
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 64,
  parameter int PPN_W      = 28,
  parameter int HA_W       = 48,
  parameter int DEVID_W    = 8,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int HPN_W     = HA_W - PAGE_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               mode64_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic               req_write_i,
  input  logic               req_xlate_i,
  output logic               resp_valid_o,
  output logic [1:0]         resp_kind_o,
  output logic [HA_W-1:0]    resp_data_o,
  output logic [DEVID_W-1:0] resp_devid_o,
  output logic               slow_req_o,
  output logic [VA_W-1:0]    slow_va_o,
  output logic               slow_write_o,
  input  logic               slow_ack_i,
  input  logic               slow_err_i,
  input  logic [PPN_W-1:0]   slow_ppn_i,
  input  logic [HPN_W-1:0]   slow_hpn_i,
  input  logic               slow_dev_i,
  input  logic               slow_cow_i
);
  ctl_state_e state_q;
  logic [VA_W-1:0] va_q;
  logic wr_q, xl_q;

  logic in_wait, accept, hit, done, refill;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic rd_valid, rd_dev, rd_cow;
  logic [VPN_W-1:0] rd_vpn;
  logic [PPN_W-1:0] rd_ppn;
  logic [HPN_W-1:0] rd_hpn;

  logic [HPN_W-1:0]      f_hpn;
  logic [PPN_W-1:0]      f_ppn;
  logic                  f_dev, f_xl;
  logic [PAGE_SHIFT-1:0] f_off;
  resp_kind_e            f_kind;
  logic [HA_W-1:0]       f_data;
  logic [DEVID_W-1:0]    f_devid;

  assign in_wait = (state_q == ST_WAIT);
  assign accept  = req_valid_i && !in_wait;
  assign done    = in_wait && slow_ack_i;
  assign refill  = done && !slow_err_i;
  assign rd_idx  = req_va_i[PAGE_SHIFT +: IDX_W];
  assign wr_idx  = va_q[PAGE_SHIFT +: IDX_W];

  xlat_tag_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .HPN_W(HPN_W)
  ) u_store (
    .clk_i, .rst_ni, .flush_i,
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_vpn_o(rd_vpn),
    .rd_ppn_o(rd_ppn), .rd_hpn_o(rd_hpn), .rd_dev_o(rd_dev), .rd_cow_o(rd_cow),
    .wr_en_i(refill), .wr_idx_i(wr_idx), .wr_vpn_i(va_q[VA_W-1:PAGE_SHIFT]),
    .wr_ppn_i(slow_ppn_i), .wr_hpn_i(slow_hpn_i),
    .wr_dev_i(slow_dev_i), .wr_cow_i(slow_cow_i)
  );

  xlat_match #(.VPN_W(VPN_W), .PAGE_SHIFT(PAGE_SHIFT)) u_match (
    .mode64_i, .req_vpn_i(req_va_i[VA_W-1:PAGE_SHIFT]), .write_i(req_write_i),
    .ent_valid_i(rd_valid), .ent_vpn_i(rd_vpn), .ent_cow_i(rd_cow), .hit_o(hit)
  );

  // answer from the table when idle, from the slow path when waiting
  assign f_hpn = in_wait ? slow_hpn_i : rd_hpn;
  assign f_ppn = in_wait ? slow_ppn_i : rd_ppn;
  assign f_dev = in_wait ? slow_dev_i : rd_dev;
  assign f_xl  = in_wait ? xl_q       : req_xlate_i;
  assign f_off = in_wait ? va_q[PAGE_SHIFT-1:0] : req_va_i[PAGE_SHIFT-1:0];

  xlat_resp_form #(
    .HA_W(HA_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W), .DEVID_W(DEVID_W)
  ) u_form (
    .hpn_i(f_hpn), .ppn_i(f_ppn), .dev_i(f_dev), .xlate_i(f_xl), .off_i(f_off),
    .kind_o(f_kind), .data_o(f_data), .devid_o(f_devid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      xl_q    <= 1'b0;
    end else if (in_wait) begin
      if (slow_ack_i) state_q <= ST_IDLE;
    end else if (accept && !hit) begin
      state_q <= ST_WAIT;
      va_q    <= req_va_i;
      wr_q    <= req_write_i;
      xl_q    <= req_xlate_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_kind_o  <= RK_MEM;
      resp_data_o  <= '0;
      resp_devid_o <= '0;
    end else begin
      resp_valid_o <= (accept && hit) || done;
      if (done && slow_err_i) begin
        resp_kind_o  <= RK_FAULT;
        resp_data_o  <= '0;
        resp_devid_o <= '0;
      end else if ((accept && hit) || done) begin
        resp_kind_o  <= f_kind;
        resp_data_o  <= f_data;
        resp_devid_o <= f_devid;
      end
    end
  end

  assign req_ready_o  = !in_wait;
  assign slow_req_o   = in_wait;
  assign slow_va_o    = va_q;
  assign slow_write_o = wr_q;

  // R4: the slow request holds its address and blocks new requests
  a_r4_slow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_req_o && !slow_ack_i |=> slow_req_o && $stable(slow_va_o) && !req_ready_o);
  // R4: a miss raises the slow request
  a_r4_miss_goes_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !hit |=> slow_req_o);
  // R2: a hit answers next cycle without the slow path
  a_r2_hit_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && hit |=> resp_valid_o && !slow_req_o);
  // R9: a failed slow lookup answers with a fault
  a_r9_fault_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_req_o && slow_ack_i && slow_err_i |=> resp_valid_o && resp_kind_o == RK_FAULT
      && resp_data_o == '0);
  // R7: device id is only driven for device answers
  a_r7_devid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && resp_kind_o != RK_DEV |-> resp_devid_o == '0);
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int CLK_NS = 20;

  typedef struct packed {
    logic [63:0] va;
    logic        wr, xl, miss, err;
    logic [27:0] ppn;
    logic [35:0] hpn;
    logic        dev, cow;
    logic [1:0]  kind;
    logic [47:0] data;
    logic [7:0]  devid;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    // R1 R5 R3: cold miss, refill, memory answer
    '{64'h1000_0123, 1'b0, 1'b0, 1'b1, 1'b0, 28'h00ABCDE, 36'h000012345, 1'b0, 1'b0, 2'd0, 48'h0000_1234_5123, 8'h00},
    // R2 R3: hit on same page
    '{64'h1000_0FF8, 1'b0, 1'b0, 1'b0, 1'b0, 28'h0, 36'h0, 1'b0, 1'b0, 2'd0, 48'h0000_1234_5FF8, 8'h00},
    // R8: translate-only hit
    '{64'h1000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 28'h0, 36'h0, 1'b0, 1'b0, 2'd2, 48'h0000_000A_BCDE, 8'h00},
    // R12: same index, other page evicts
    '{64'h2000_0010, 1'b0, 1'b0, 1'b1, 1'b0, 28'h1, 36'h000000009, 1'b0, 1'b0, 2'd0, 48'h0000_0000_9010, 8'h00},
    // R12: first page now misses
    '{64'h1000_0004, 1'b0, 1'b0, 1'b1, 1'b0, 28'h00ABCDE, 36'h000012345, 1'b0, 1'b0, 2'd0, 48'h0000_1234_5004, 8'h00},
    // R7: device refill
    '{64'h0000_3040, 1'b0, 1'b0, 1'b1, 1'b0, 28'h3, 36'hA50000002, 1'b1, 1'b0, 2'd1, 48'h0000_0000_2040, 8'hA5},
    // R7: device hit
    '{64'h0000_3100, 1'b0, 1'b0, 1'b0, 1'b0, 28'h0, 36'h0, 1'b0, 1'b0, 2'd1, 48'h0000_0000_2100, 8'hA5},
    // R6: copy-on-write page refill
    '{64'h0000_5008, 1'b0, 1'b0, 1'b1, 1'b0, 28'h5, 36'h000000007, 1'b0, 1'b1, 2'd0, 48'h0000_0000_7008, 8'h00},
    // R6: read still hits
    '{64'h0000_5010, 1'b0, 1'b0, 1'b0, 1'b0, 28'h0, 36'h0, 1'b0, 1'b0, 2'd0, 48'h0000_0000_7010, 8'h00},
    // R6: write forced to slow path
    '{64'h0000_5020, 1'b1, 1'b0, 1'b1, 1'b0, 28'h5, 36'h000000008, 1'b0, 1'b0, 2'd0, 48'h0000_0000_8020, 8'h00},
    // R6: write hits once the flag is gone
    '{64'h0000_5030, 1'b1, 1'b0, 1'b0, 1'b0, 28'h0, 36'h0, 1'b0, 1'b0, 2'd0, 48'h0000_0000_8030, 8'h00},
    // R9: slow error gives fault
    '{64'h0000_6000, 1'b0, 1'b1, 1'b1, 1'b1, 28'h0, 36'h0, 1'b0, 1'b0, 2'd3, 48'h0, 8'h00},
    // R9: no refill after error, R8 page answer
    '{64'h0000_6000, 1'b0, 1'b1, 1'b1, 1'b0, 28'h0000066, 36'h000000006, 1'b0, 1'b0, 2'd2, 48'h0000_0000_0066, 8'h00},
    // R10: high address, 64-bit mode
    '{64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 28'h8, 36'h000000004, 1'b0, 1'b0, 2'd0, 48'h0000_0000_4000, 8'h00},
    // R10: upper bits differ, misses in 64-bit mode
    '{64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 28'h8, 36'h000000044, 1'b0, 1'b0, 2'd0, 48'h0000_0004_4000, 8'h00},
    // R2: hit
    '{64'h0000_0000_8000_0010, 1'b0, 1'b0, 1'b0, 1'b0, 28'h0, 36'h0, 1'b0, 1'b0, 2'd0, 48'h0000_0004_4010, 8'h00}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        flush = 1'b0, mode64 = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_xlate = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_ready, resp_valid, slow_req, slow_write;
  logic [1:0]  resp_kind;
  logic [47:0] resp_data;
  logic [7:0]  resp_devid;
  logic [63:0] slow_va;
  logic        slow_ack = 1'b0, slow_err = 1'b0, slow_dev = 1'b0, slow_cow = 1'b0;
  logic [27:0] slow_ppn = '0;
  logic [35:0] slow_hpn = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  xlat_cache u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .mode64_i(mode64),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_write_i(req_write), .req_xlate_i(req_xlate),
    .resp_valid_o(resp_valid), .resp_kind_o(resp_kind), .resp_data_o(resp_data),
    .resp_devid_o(resp_devid), .slow_req_o(slow_req), .slow_va_o(slow_va),
    .slow_write_o(slow_write), .slow_ack_i(slow_ack), .slow_err_i(slow_err),
    .slow_ppn_i(slow_ppn), .slow_hpn_i(slow_hpn), .slow_dev_i(slow_dev),
    .slow_cow_i(slow_cow)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_va = v.va; req_write = v.wr; req_xlate = v.xl;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.miss) begin
      chk(slow_req === 1'b1, {rq, " R4 slow_req"}, 64'(slow_req), 64'd1);
      chk(slow_va === v.va, {rq, " R4 slow_va"}, slow_va, v.va);
      chk(slow_write === v.wr, {rq, " R4 slow_write"}, 64'(slow_write), 64'(v.wr));
      chk(req_ready === 1'b0, {rq, " R4 ready low"}, 64'(req_ready), 64'd0);
      for (int k = 0; k < 2; k++) @(negedge clk);
      chk(slow_req === 1'b1 && req_ready === 1'b0 && slow_va === v.va,
          {rq, " R4 hold"}, 64'(slow_req), 64'd1);
      slow_ack = 1'b1; slow_err = v.err; slow_ppn = v.ppn; slow_hpn = v.hpn;
      slow_dev = v.dev; slow_cow = v.cow;
      @(negedge clk);
      slow_ack = 1'b0; slow_err = 1'b0;
    end else begin
      chk(slow_req === 1'b0, {rq, " R2 no slow_req"}, 64'(slow_req), 64'd0);
    end
    chk(resp_valid === 1'b1, {rq, " resp_valid"}, 64'(resp_valid), 64'd1);
    chk(resp_kind === v.kind, {rq, " kind"}, 64'(resp_kind), 64'(v.kind));
    chk(resp_data === v.data, {rq, " data"}, 64'(resp_data), 64'(v.data));
    chk(resp_devid === v.devid, {rq, " devid"}, 64'(resp_devid), 64'(v.devid));
    chk(req_ready === 1'b1, {rq, " ready back"}, 64'(req_ready), 64'd1);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(resp_valid === 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
    chk(slow_req === 1'b0, "R1 slow_req", 64'(slow_req), 64'd0);

    for (int i = 0; i < NV; i++) run(TBL[i], $sformatf("vec%0d", i));

    // R11: flush empties a page that was valid
    do_flush();
    run('{64'h0000_5030, 1'b0, 1'b0, 1'b1, 1'b0, 28'h5, 36'h000000008, 1'b0, 1'b0,
          2'd0, 48'h0000_0000_8030, 8'h00}, "R11 miss after flush");

    // R10: 32-bit mode compares only the low 32 bits
    mode64 = 1'b0; do_flush();
    run('{64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 28'h8, 36'h000000044, 1'b0, 1'b0,
          2'd0, 48'h0000_0004_4000, 8'h00}, "R10 refill m32");
    run('{64'hFFFF_FFFF_8000_0020, 1'b0, 1'b0, 1'b0, 1'b0, 28'h0, 36'h0, 1'b0, 1'b0,
          2'd0, 48'h0000_0004_4020, 8'h00}, "R10 hit m32");
    mode64 = 1'b1; do_flush();
    run('{64'hFFFF_FFFF_8000_0020, 1'b0, 1'b0, 1'b1, 1'b0, 28'h8, 36'h000000004, 1'b0, 1'b0,
          2'd0, 48'h0000_0000_4020, 8'h00}, "R10 miss m64");

    @(negedge clk);
    chk(resp_valid === 1'b0, "R2 single-cycle resp", 64'(resp_valid), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule